// File: doc/BRIEF.md
# Exposure and Dual-Slope Integration Sequencer

This block turns two free-running exposure pins into the pixel-array control strobes for one capture cycle. Both pins are brought into the sensor clock domain and filtered so that a level counts only after it has held for a minimum number of clocks. A rise on the first pin starts integration, and a fall ends it. The second pin, when dual slope is enabled, ends the dual-slope reset phase and starts the second integration slope.

When integration ends, the block opens the frame overhead time (FOT). It pulses the pixel sample strobe at the start of the FOT and returns the array to reset for the rest of it. If a window readout is still running when the first pin falls, the block first asks the readout to stop. It waits until the current line has completed before the FOT starts. Exposure activity during the FOT is ignored. A dual-slope pin still high at the end of the FOT sets a sticky error flag.

Top module: `exp_ds_sequencer`

## Requirements
- R1: A pin level takes effect only after it has been seen, after a two-stage synchronizer, on HOLD_CYCLES (15) consecutive clocks. A pulse shorter than that has no effect on any output.
- R2: While idle, a filtered rise of the first pin starts integration. pix_reset_o then drops to 0 and stays 0 until the FOT sample window ends.
- R3: With ro_busy_i low, a filtered fall of the first pin during integration raises fot_o for exactly FOT_CYCLES (32) clocks. The block then returns to idle with pix_reset_o at 1.
- R4: pix_sample_o is 1 for the first SAMPLE_CYCLES (4) clocks of the FOT and 0 at all other times. pix_reset_o returns to 1 for the remaining FOT clocks.
- R5: If ro_busy_i is high when the first pin falls, ro_abort_o goes to 1 and the FOT is held off. The FOT starts on the clock after line_done_i is 1, or after ro_busy_i drops. ro_abort_o and fot_o are never both 1.
- R6: With ds_en_i at 1, pix_reset_ds_o is 1 from the start of integration until a filtered rise of the second pin during integration.
- R7: With ds_en_i at 0, pix_reset_ds_o stays 0, and the second pin has no effect on any output, including ds_err_o.
- R8: Exposure edges that occur during the FOT are ignored. A new integration needs a fresh rise of the first pin after the FOT has ended.
- R9: With ds_en_i at 1, if the filtered second pin is high on the last FOT clock, ds_err_o goes to 1 and stays 1 until reset.
- R10: After reset, pix_reset_o is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exp1_i | input | 1 | First exposure pin, asynchronous |
| exp2_i | input | 1 | Second (dual-slope) exposure pin, asynchronous |
| ds_en_i | input | 1 | Dual-slope enable |
| ro_busy_i | input | 1 | Window readout in progress |
| line_done_i | input | 1 | Current readout line has completed |
| pix_reset_o | output | 1 | Pixel array reset |
| pix_reset_ds_o | output | 1 | Dual-slope pixel reset |
| pix_sample_o | output | 1 | Pixel sample strobe |
| fot_o | output | 1 | Frame overhead time active |
| ro_abort_o | output | 1 | Request to stop readout at the line boundary |
| ds_err_o | output | 1 | Sticky flag: second pin still high at FOT end |

## Verification
The assertions check several relations on every cycle: the filtered level only ever moves toward the synchronized level, the hold counter stays in range, the sample strobe stays inside the FOT, abort and FOT never overlap, an integration is only entered from idle, and the error flag never clears. Several properties can only be shown by the bench's scenarios: the exact 15-clock acceptance of a pin level, a short glitch leaving every output untouched, and the 32-clock FOT length with its 4-clock sample window. The scenarios also show the line-boundary hold-off under a busy readout, an exposure rise swallowed by the FOT, and the second pin being ignored with dual slope disabled.

// File: rtl/exp_seq_pkg.sv
package exp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FOT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/exp_deglitch.sv
module exp_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   filt_q;
  logic [CW-1:0]          run_q;
  logic                   sync_lvl;

  assign sync_lvl = chain_q[SYNC_STAGES-1];
  assign level_o  = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      filt_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
      if (sync_lvl == filt_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        filt_q <= sync_lvl;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // filtered level only ever moves to the synchronized level
  assert_filt_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(sync_lvl) == filt_q));

  assert_run_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST);
endmodule

// File: rtl/exp_fot_ctrl.sv
module exp_fot_ctrl
  import exp_seq_pkg::*;
#(
  parameter int FOT_CYCLES    = 32,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e1_i,
  input  logic e2_i,
  input  logic ds_en_i,
  input  logic ro_busy_i,
  input  logic line_done_i,
  output logic pix_reset_o,
  output logic pix_reset_ds_o,
  output logic pix_sample_o,
  output logic fot_o,
  output logic ro_abort_o,
  output logic ds_err_o
);
  localparam int CW = $clog2(FOT_CYCLES);
  localparam logic [CW-1:0] FOT_LAST   = CW'(FOT_CYCLES - 1);
  localparam logic [CW-1:0] SAMPLE_END = CW'(SAMPLE_CYCLES);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] fot_cnt_q;
  logic          e1_q, e2_q;
  logic          ds_go_q, ds_err_q;
  logic          rise1, fall1, rise2, fot_last;

  assign rise1    = e1_i & ~e1_q;
  assign fall1    = ~e1_i & e1_q;
  assign rise2    = e2_i & ~e2_q;
  assign fot_last = (state_q == ST_FOT) && (fot_cnt_q == FOT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rise1) state_d = ST_INTEG;
      ST_INTEG: if (fall1) state_d = ro_busy_i ? ST_DRAIN : ST_FOT;
      ST_DRAIN: if (line_done_i || !ro_busy_i) state_d = ST_FOT;
      ST_FOT:   if (fot_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fot_cnt_q <= '0;
      e1_q      <= 1'b0;
      e2_q      <= 1'b0;
      ds_go_q   <= 1'b0;
      ds_err_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      e1_q    <= e1_i;
      e2_q    <= e2_i;
      if (state_q == ST_FOT) fot_cnt_q <= fot_last ? '0 : fot_cnt_q + 1'b1;
      if (state_q == ST_IDLE) ds_go_q <= 1'b0;
      else if (state_q == ST_INTEG && ds_en_i && rise2) ds_go_q <= 1'b1;
      if (fot_last && ds_en_i && e2_i) ds_err_q <= 1'b1;
    end
  end

  assign pix_sample_o   = (state_q == ST_FOT) && (fot_cnt_q < SAMPLE_END);
  assign pix_reset_o    = (state_q == ST_IDLE) ||
                          ((state_q == ST_FOT) && (fot_cnt_q >= SAMPLE_END));
  assign pix_reset_ds_o = ds_en_i && (state_q == ST_INTEG) && !ds_go_q;
  assign fot_o          = (state_q == ST_FOT);
  assign ro_abort_o     = (state_q == ST_DRAIN);
  assign ds_err_o       = ds_err_q;

  assert_sample_in_fot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sample_o |-> fot_o);

  assert_abort_vs_fot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ro_abort_o && fot_o));

  assert_fot_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FOT && $past(state_q) != ST_FOT) |->
      ($past(state_q) == ST_INTEG || $past(state_q) == ST_DRAIN));

  assert_integ_from_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INTEG && $past(state_q) != ST_INTEG) |-> $past(state_q) == ST_IDLE);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ds_err_q) |-> ds_err_q);
endmodule

// File: rtl/exp_ds_sequencer.sv
module exp_ds_sequencer #(
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_CYCLES   = 15,
  parameter int FOT_CYCLES    = 32,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exp1_i,
  input  logic exp2_i,
  input  logic ds_en_i,
  input  logic ro_busy_i,
  input  logic line_done_i,
  output logic pix_reset_o,
  output logic pix_reset_ds_o,
  output logic pix_sample_o,
  output logic fot_o,
  output logic ro_abort_o,
  output logic ds_err_o
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pins, lvl;
  assign pins = {exp2_i, exp1_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    exp_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYCLES(HOLD_CYCLES)
    ) u_dg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .level_o(lvl[g])
    );
  end

  exp_fot_ctrl #(
    .FOT_CYCLES   (FOT_CYCLES),
    .SAMPLE_CYCLES(SAMPLE_CYCLES)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .e1_i          (lvl[0]),
    .e2_i          (lvl[1]),
    .ds_en_i       (ds_en_i),
    .ro_busy_i     (ro_busy_i),
    .line_done_i   (line_done_i),
    .pix_reset_o   (pix_reset_o),
    .pix_reset_ds_o(pix_reset_ds_o),
    .pix_sample_o  (pix_sample_o),
    .fot_o         (fot_o),
    .ro_abort_o    (ro_abort_o),
    .ds_err_o      (ds_err_o)
  );
endmodule

// File: tb/tb_exp_ds_sequencer.sv
`timescale 1ns/1ps
module tb_exp_ds_sequencer;
  localparam int HOLD = 15;
  localparam int FOTN = 32;
  localparam int SMPN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exp1 = 1'b0, exp2 = 1'b0, ds_en = 1'b0, busy = 1'b0, ldone = 1'b0;
  logic prst, prst_ds, psmp, fot, abort, err;

  int checks = 0;
  int fails = 0;
  bit running = 1'b1;

  always #2 clk = ~clk;

  exp_ds_sequencer #(.HOLD_CYCLES(HOLD), .FOT_CYCLES(FOTN), .SAMPLE_CYCLES(SMPN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .exp1_i(exp1), .exp2_i(exp2), .ds_en_i(ds_en),
    .ro_busy_i(busy), .line_done_i(ldone), .pix_reset_o(prst), .pix_reset_ds_o(prst_ds),
    .pix_sample_o(psmp), .fot_o(fot), .ro_abort_o(abort), .ds_err_o(err));

  // behavioural reference: 0 idle, 1 integrating, 2 waiting for line end, 3 overhead
  int m_sync[2][2];
  int m_filt[2], m_run[2], m_prev[2];
  int m_mode, m_fcnt, m_dsgo, m_err;

  task automatic model_clear();
    for (int p = 0; p < 2; p++) begin
      m_sync[p][0] = 0; m_sync[p][1] = 0; m_filt[p] = 0; m_run[p] = 0; m_prev[p] = 0;
    end
    m_mode = 0; m_fcnt = 0; m_dsgo = 0; m_err = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      int f1, f2, nmode, last;
      int pin[2];
      pin[0] = exp1; pin[1] = exp2;
      f1 = m_filt[0]; f2 = m_filt[1];
      last = (m_mode == 3 && m_fcnt == FOTN - 1);
      nmode = m_mode;
      case (m_mode)
        0: if (f1 && !m_prev[0]) nmode = 1;
        1: if (!f1 && m_prev[0]) nmode = busy ? 2 : 3;
        2: if (ldone || !busy) nmode = 3;
        default: if (last) nmode = 0;
      endcase
      if (m_mode == 0) m_dsgo = 0;
      else if (m_mode == 1 && ds_en && f2 && !m_prev[1]) m_dsgo = 1;
      if (last && ds_en && f2) m_err = 1;
      if (m_mode == 3) m_fcnt = last ? 0 : m_fcnt + 1;
      m_prev[0] = f1; m_prev[1] = f2;
      m_mode = nmode;
      for (int p = 0; p < 2; p++) begin
        int s;
        s = m_sync[p][1];
        if (s == m_filt[p]) m_run[p] = 0;
        else if (m_run[p] == HOLD - 1) begin m_filt[p] = s; m_run[p] = 0; end
        else m_run[p] = m_run[p] + 1;
        m_sync[p][1] = m_sync[p][0];
        m_sync[p][0] = pin[p];
      end
    end
  end

  task automatic check(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", req, name, $time, act, exp);
    end
  endtask

  // compare every output on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      check("R2", "pix_reset", prst, logic'(m_mode == 0 || (m_mode == 3 && m_fcnt >= SMPN)));
      check("R4", "pix_sample", psmp, logic'(m_mode == 3 && m_fcnt < SMPN));
      check("R3", "fot", fot, logic'(m_mode == 3));
      check("R5", "ro_abort", abort, logic'(m_mode == 2));
      check(ds_en ? "R6" : "R7", "pix_reset_ds", prst_ds,
            logic'(ds_en && m_mode == 1 && !m_dsgo));
      check("R9", "ds_err", err, logic'(m_err != 0));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired at %0t", $time);
    report();
  end

  initial begin
    model_clear();
    wait_cyc(3);
    // R10: reset values seen while reset is applied
    check("R10", "pix_reset reset", prst, 1'b1);
    check("R10", "fot reset", fot, 1'b0);
    check("R10", "ds_err reset", err, 1'b0);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: short glitch on the first pin, no integration may start
    exp1 = 1'b1; wait_cyc(10); exp1 = 1'b0; wait_cyc(30);
    check("R1", "glitch ignored", prst, 1'b1);
    // R1: a pulse one clock short of the hold length is still ignored
    exp1 = 1'b1; wait_cyc(HOLD - 1); exp1 = 1'b0; wait_cyc(30);
    check("R1", "short pulse ignored", prst, 1'b1);

    // R2 R3 R4 R6: dual-slope cycle with idle readout
    ds_en = 1'b1;
    exp1 = 1'b1; wait_cyc(40);
    check("R2", "integrating", prst, 1'b0);
    check("R6", "ds reset active", prst_ds, 1'b1);
    exp2 = 1'b1; wait_cyc(30);
    check("R6", "ds reset released", prst_ds, 1'b0);
    exp1 = 1'b0; exp2 = 1'b0; wait_cyc(70);

    // R5: first pin falls while readout is busy
    exp1 = 1'b1; wait_cyc(40);
    busy = 1'b1;
    exp1 = 1'b0; wait_cyc(30);
    check("R5", "abort held", abort, 1'b1);
    ldone = 1'b1; wait_cyc(1); ldone = 1'b0; busy = 1'b0;
    wait_cyc(60);

    // R7: dual slope off, second pin toggles and stays high across overhead
    ds_en = 1'b0;
    exp1 = 1'b1; wait_cyc(25);
    exp2 = 1'b1; wait_cyc(25); exp2 = 1'b0; wait_cyc(25); exp2 = 1'b1; wait_cyc(25);
    exp1 = 1'b0; wait_cyc(70);
    check("R7", "no error with ds off", err, 1'b0);
    exp2 = 1'b0; wait_cyc(30);

    // R8: rise of the first pin inside the overhead is swallowed
    exp1 = 1'b1; wait_cyc(40);
    exp1 = 1'b0; wait_cyc(20);
    exp1 = 1'b1; wait_cyc(60);
    check("R8", "no restart after overhead", prst, 1'b1);
    exp1 = 1'b0; wait_cyc(25);
    exp1 = 1'b1; wait_cyc(40);
    check("R8", "fresh rise integrates", prst, 1'b0);
    exp1 = 1'b0; wait_cyc(60);

    // R9: second pin left high through the overhead with dual slope on
    ds_en = 1'b1;
    exp1 = 1'b1; wait_cyc(30);
    exp2 = 1'b1; wait_cyc(30);
    exp1 = 1'b0; wait_cyc(70);
    check("R9", "error set", err, 1'b1);
    exp2 = 1'b0; wait_cyc(20);
    exp1 = 1'b1; wait_cyc(40); exp1 = 1'b0; wait_cyc(70);
    check("R9", "error sticky", err, 1'b1);

    report();
  end
endmodule